// File: doc/BRIEF.md
# Write Inhibit Guard

This block sits between the external strobes of a nonvolatile memory and the state machine that starts a programming cycle. It reads an asynchronous supply-good flag from a voltage comparator, along with the active-low chip select, output enable and write enable lines. It then decides whether a write may begin. A write can only begin when the supply has been good for long enough, the output driver is not enabled, and the select and write strobes have been held low together for longer than a glitch.

The block drives two outputs. The write-start output is a single-cycle pulse that goes to the programming sequencer. The write-allowed output is a level that reports whether the power conditions currently permit a write. All time limits are counted in clock cycles, so the integrating chip sets them from its clock frequency. For example, 5 ms of hold-off is 500,000 cycles at 100 MHz.

Top module: `wr_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with the supply flag low, `wr_allowed` and `wr_start` are 0.
- R2: `supply_ok_async` passes through a two-stage synchronizer. After the input falls, `wr_allowed` is still 1 one clock edge later and is 0 after the second edge.
- R3: When `supply_ok_async` rises and stays high, `wr_allowed` is still 0 after HOLD_CYC+1 clock edges and becomes 1 after HOLD_CYC+2 edges.
- R4: While the synchronized supply flag is low, `wr_allowed` is 0 and no `wr_start` pulse is produced.
- R5: If the supply drops during the hold-off, the count is discarded. When the supply recovers, the full HOLD_CYC hold-off is counted again from the new rising edge.
- R6: A strobe is active when `cs_n`=0, `we_n`=0 and `oe_n`=1. Once the strobe has been active for MIN_SAMPLES consecutive clock samples while `wr_allowed` is 1, `wr_start` is 1 for exactly one cycle. That cycle directly follows the edge that took the MIN_SAMPLES-th sample.
- R7: An active strobe lasting fewer than MIN_SAMPLES consecutive samples produces no `wr_start`.
- R8: With `oe_n`=0 no write starts. If `oe_n` goes low in the middle of a strobe, the sample count restarts from zero.
- R9: A strobe held active for any length produces only one `wr_start`. The next pulse needs the strobe to go inactive first.
- R10: A strobe that reaches MIN_SAMPLES while `wr_allowed` is 0 is dropped. It does not fire later, even if `wr_allowed` rises while the strobe is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_async | input | 1 | Asynchronous supply-good flag from the comparator |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_start | output | 1 | One-cycle pulse that starts a programming cycle |
| wr_allowed | output | 1 | High when the hold-off has expired and the supply is good |

## Verification
The bench looks at the exact edge on which `wr_allowed` rises. An off-by-one counter or a missing synchronizer stage would move that rise by a cycle. It also drops the supply partway through the hold-off and checks that the full count runs again. A counter that only paused would enable writes too early. Strobes one sample short of the threshold, and strobes interrupted by output enable, show whether the filter accumulates samples instead of restarting. A long strobe held across the end of the hold-off shows whether a pulse that was blocked is kept and fired late, or fires more than once.

// File: rtl/wg_pkg.sv
package wg_pkg;

   // Width of a counter that must hold the value n.
   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wg_holdoff.sv
module wg_holdoff
   import wg_pkg::*;
#(
   parameter int HOLD_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ok,
   output logic done
);
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("wg_holdoff: HOLD_CYC must be at least 1");
   end

   localparam int HW = cnt_w(HOLD_CYC);
   localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

   logic [HW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!ok) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) done <= 1'b1;
      end
   end

   // The hold-off can only be complete while the supply is good.
   p_done_needs_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(ok));
endmodule

// File: rtl/wg_strobe_filter.sv
module wg_strobe_filter
   import wg_pkg::*;
#(
   parameter int MIN_SAMPLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic fire
);
   if (MIN_SAMPLES < 1) begin : g_bad_min
      $error("wg_strobe_filter: MIN_SAMPLES must be at least 1");
   end

   if (MIN_SAMPLES == 1) begin : g_edge
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev <= 1'b0;
         else        prev <= active;
      end
      assign fire = active && !prev;
   end else begin : g_count
      localparam int RW = cnt_w(MIN_SAMPLES);
      localparam logic [RW-1:0] FULL = RW'(MIN_SAMPLES);
      localparam logic [RW-1:0] PRE  = RW'(MIN_SAMPLES - 1);
      logic [RW-1:0] run;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          run <= '0;
         else if (!active)    run <= '0;
         else if (run != FULL) run <= run + 1'b1;
      end
      assign fire = active && (run == PRE);
   end

   // One qualification per strobe.
   p_single_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
endmodule

// File: rtl/wr_guard.sv
module wr_guard
   import wg_pkg::*;
#(
   parameter int HOLD_CYC    = 500000,
   parameter int MIN_SAMPLES = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_async,
   input  logic cs_n,
   input  logic oe_n,
   input  logic we_n,
   output logic wr_start,
   output logic wr_allowed
);
   logic supply_ok;
   logic hold_done;
   logic strobe_act;
   logic strobe_fire;

   wg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(supply_ok_async), .q_sync(supply_ok));

   wg_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .ok(supply_ok), .done(hold_done));

   assign strobe_act = !cs_n && !we_n && oe_n;

   wg_strobe_filter #(.MIN_SAMPLES(MIN_SAMPLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .active(strobe_act), .fire(strobe_fire));

   assign wr_allowed = hold_done && supply_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_start <= 1'b0;
      else        wr_start <= strobe_fire && wr_allowed;
   end

   // ---------------- checker counters ----------------
   localparam int HW = cnt_w(HOLD_CYC);
   localparam int AW = cnt_w(MIN_SAMPLES);
   localparam logic [HW-1:0] HFULL = HW'(HOLD_CYC);
   localparam logic [AW-1:0] AFULL = AW'(MIN_SAMPLES);
   localparam logic [AW-1:0] APRE  = AW'(MIN_SAMPLES - 1);

   logic [HW-1:0] chk_ok_run;
   logic [AW-1:0] chk_act_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_ok_run  <= '0;
         chk_act_run <= '0;
      end else begin
         if (!supply_ok)              chk_ok_run <= '0;
         else if (chk_ok_run != HFULL) chk_ok_run <= chk_ok_run + 1'b1;
         if (!strobe_act)              chk_act_run <= '0;
         else if (chk_act_run != AFULL) chk_act_run <= chk_act_run + 1'b1;
      end
   end

   p_sync_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_allowed |-> $past(supply_ok_async, 2));

   p_full_holdoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_allowed |-> (chk_ok_run == HFULL));

   p_start_needs_allowed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> $past(wr_allowed));

   p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !wr_start);

   p_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> ($past(strobe_act) && ($past(chk_act_run) == APRE)));

   p_oe_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> ($past(oe_n) && !$past(cs_n) && !$past(we_n)));
endmodule

// File: tb/wr_guard_tb.sv
module wr_guard_tb;
   localparam int HOLD = 20;
   localparam int G    = 3;

   logic clk = 1'b0;
   logic rst_n, supply, cs_n, oe_n, we_n;
   logic wr_start, wr_allowed;
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   finished = 1'b0;

   typedef struct { int cyc; string tag; } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wr_guard #(.HOLD_CYC(HOLD), .MIN_SAMPLES(G), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok_async(supply),
      .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .wr_start(wr_start), .wr_allowed(wr_allowed));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic act, input logic expv, input string tag);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s cycle %0d actual=%0b expected=%0b", tag, cyc, act, expv);
      end
   endtask

   // Driver: one strobe of len cycles; pushes the expected pulse cycle.
   task automatic strobe(input int len, input logic oe_v, input bit exp_pulse,
                         input string tag);
      exp_t e;
      cs_n = 1'b0; we_n = 1'b0; oe_n = oe_v;
      if (exp_pulse) begin
         e.cyc = cyc + G; e.tag = tag;
         q.push_back(e);
      end
      tick(len);
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      tick(4);
   endtask

   // Monitor: pops expectations as pulses appear.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (q.size() != 0 && cyc > q[0].cyc) begin
            exp_t m;
            m = q.pop_front();
            checks++; fails++;
            $display("FAIL %s missed wr_start actual=none expected=cycle %0d", m.tag, m.cyc);
         end
         if (wr_start) begin
            checks++;
            if (q.size() == 0) begin
               fails++;
               $display("FAIL R4 R7 R8 R9 R10 unexpected wr_start actual=cycle %0d expected=none", cyc);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (e.cyc != cyc) begin
                  fails++;
                  $display("FAIL %s wr_start actual=cycle %0d expected=cycle %0d", e.tag, cyc, e.cyc);
               end
            end
         end
      end
   end

   initial begin
      int c;
      exp_t e;
      rst_n = 1'b0; supply = 1'b0; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      tick(3);
      chk(wr_allowed, 1'b0, "R1 allowed in reset");
      chk(wr_start, 1'b0, "R1 start in reset");
      rst_n = 1'b1;
      tick(1);
      chk(wr_allowed, 1'b0, "R1 allowed after reset");

      // R3 hold-off timing
      supply = 1'b1;
      tick(HOLD + 1);
      chk(wr_allowed, 1'b0, "R3 before hold-off end");
      tick(1);
      chk(wr_allowed, 1'b1, "R3 at hold-off end");

      strobe(G, 1'b1, 1'b1, "R6");
      strobe(G - 1, 1'b1, 1'b0, "R7");
      strobe(1, 1'b1, 1'b0, "R7");
      strobe(10, 1'b1, 1'b1, "R9");
      strobe(10, 1'b0, 1'b0, "R8");

      // R8: output enable mid-strobe restarts the count
      cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      tick(2);
      oe_n = 1'b0;
      tick(1);
      oe_n = 1'b1;
      e.cyc = cyc + G; e.tag = "R8";
      q.push_back(e);
      tick(G + 2);
      cs_n = 1'b1; we_n = 1'b1;
      tick(4);

      // R2 / R4: supply drop
      supply = 1'b0;
      tick(1);
      chk(wr_allowed, 1'b1, "R2 one edge after drop");
      tick(1);
      chk(wr_allowed, 1'b0, "R2 R4 two edges after drop");
      strobe(6, 1'b1, 1'b0, "R4");
      chk(wr_allowed, 1'b0, "R4 still low");

      // R5 restart, R10 held strobe across the end of the hold-off
      supply = 1'b1;
      tick(8);
      supply = 1'b0;
      tick(3);
      supply = 1'b1;
      c = cyc;
      tick(5);
      cs_n = 1'b0; we_n = 1'b0;
      tick(HOLD - 4);
      chk(wr_allowed, 1'b0, "R5 restarted hold-off");
      tick(1);
      chk(wr_allowed, 1'b1, "R5 full hold-off done");
      if (cyc != c + HOLD + 2) begin
         checks++; fails++;
         $display("FAIL R5 bench timing actual=%0d expected=%0d", cyc, c + HOLD + 2);
      end
      tick(6);
      chk(wr_start, 1'b0, "R10 no late pulse");
      cs_n = 1'b1; we_n = 1'b1;
      tick(4);

      strobe(G, 1'b1, 1'b1, "R6 after recovery");
      tick(6);
      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R6 pending pulses actual=%0d expected=0", q.size());
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule